// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 level-sensitive interrupt requests and forwards them to a primary vectored interrupt controller in two ways. All sources that are both active and enabled are ORed onto a single cascade line. A contiguous band of sources can also be routed straight to the primary controller's line of the same index. Those routed lines follow the raw request level, whatever the enable mask holds.

Software reaches the block through a simple word-addressed register bus inside a 4 KB window. The register index is the byte address divided by four. The registers give raw and masked status, set and clear access to the enable mask, a soft-interrupt pair that controls mask bit 0, and set and clear access to the pass-through enables. Priority and vectoring are left to the primary controller.

Top module: `sec_irq_ctrl`

## Requirements
- R1: The raw level register captures `irq_in` on every clock edge. Reading index 1 returns it.
- R2: Reading index 0 returns raw levels AND enable mask. Reading index 2 returns the enable mask.
- R3: A write to index 2 ORs the written word into the enable mask. A write to index 3 clears every mask bit that is 1 in the written word.
- R4: A nonzero write to index 4 sets mask bit 0, and a zero write there changes nothing. A nonzero write to index 5 clears mask bit 0. Reading index 4 returns raw level bit 0 in bit 0, with all other bits zero.
- R5: A write to index 8 ORs only bits 21 to 30 of the written word (mask 0x7FE00000) into the pass-through enables. Reading index 8 returns the pass-through enables.
- R6: A write to index 9 clears every pass-through enable bit that is 1 in the written word.
- R7: For each line 21 to 30 whose pass-through enable is set, `irq_out[i]` follows raw input i, regardless of the enable mask. When that enable is clear, the line is low.
- R8: `irq_out[31]` is high exactly when raw levels AND enable mask is nonzero.
- R9: `irq_out[20:0]` stays low at all times.
- R10: Reads at any index other than 0, 1, 2, 4 and 8 return zero. Writes at any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R11: A synchronous active-high reset clears the raw levels, the enable mask and the pass-through enables, and drives every output low.
- R12: `irq_out` updates on the same clock edge that samples an input change or a register write. `prdata` is combinational from the current state and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| psel | input | 1 | Register access select |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| irq_out | output | 32 | Lines to the primary controller; bit 31 is the cascade |

## Verification
The bench builds the block with its default parameters: 32 lines, a 12-bit address, a pass-through band of 21 to 30, and the cascade on line 31. This puts every boundary of the band within reach of the bench: line 20 just below it, line 31 just above it, and both edges of the set mask. Vector rows combine different input, mask and pass-through patterns, and the expected lines and reads are computed from the requirements. Directed tests cover reset under active inputs, the soft-interrupt pair with zero and nonzero data, pass-through release, and holes in the register map.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Register indices (byte address >> 2)
  localparam int unsigned IDX_STAT    = 0;
  localparam int unsigned IDX_RAW     = 1;
  localparam int unsigned IDX_EN      = 2;
  localparam int unsigned IDX_ENCLR   = 3;
  localparam int unsigned IDX_SOFT    = 4;
  localparam int unsigned IDX_SOFTCLR = 5;
  localparam int unsigned IDX_PT      = 8;
  localparam int unsigned IDX_PTCLR   = 9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_LINES-1:0] PT_MASK = 32'h7FE0_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  output logic [NUM_LINES-1:0] level_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pten_q,
  output logic [NUM_LINES-1:0] mask_d,
  output logic [NUM_LINES-1:0] pten_d
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  logic             wen;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];
  assign wen        = sel && wr;

  always_comb begin
    mask_d = mask_q;
    pten_d = pten_q;
    if (wen) begin
      if (idx == IDX_W'(IDX_EN))      mask_d = mask_q | wdata;
      if (idx == IDX_W'(IDX_ENCLR))   mask_d = mask_q & ~wdata;
      if (idx == IDX_W'(IDX_SOFT) && (|wdata))    mask_d[0] = 1'b1;
      if (idx == IDX_W'(IDX_SOFTCLR) && (|wdata)) mask_d[0] = 1'b0;
      if (idx == IDX_W'(IDX_PT))      pten_d = pten_q | (wdata & PT_MASK);
      if (idx == IDX_W'(IDX_PTCLR))   pten_d = pten_q & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      mask_q  <= '0;
      pten_q  <= '0;
    end else begin
      level_q <= irq_in;
      mask_q  <= mask_d;
      pten_q  <= pten_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(IDX_STAT))      rdata = level_q & mask_q;
    else if (idx == IDX_W'(IDX_RAW))  rdata = level_q;
    else if (idx == IDX_W'(IDX_EN))   rdata = mask_q;
    else if (idx == IDX_W'(IDX_SOFT)) rdata = {{(NUM_LINES-1){1'b0}}, level_q[0]};
    else if (idx == IDX_W'(IDX_PT))   rdata = pten_q;
  end

  // R1
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> level_q == $past(irq_in));
  // R3
  enset_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wen && idx == IDX_W'(IDX_EN)) |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R3
  enclr_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wen && idx == IDX_W'(IDX_ENCLR)) |=> ((mask_q & $past(wdata)) == '0));
  // R5
  pt_band_chk: assert property (@(posedge clk) disable iff (rst)
    (pten_q & ~PT_MASK) == '0);
  // R6
  ptclr_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wen && idx == IDX_W'(IDX_PTCLR)) |=> ((pten_q & $past(wdata)) == '0));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int NUM_LINES = 32,
  parameter int PT_LO     = 21,
  parameter int PT_HI     = 30,
  parameter int CASC      = 31,
  parameter logic [NUM_LINES-1:0] PT_MASK = 32'h7FE0_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mask_d,
  input  logic [NUM_LINES-1:0] pten_d,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] out_d;
  logic                 unused_pt;

  assign unused_pt = ^(pten_d & ~PT_MASK);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == CASC) begin : g_casc
      assign out_d[i] = |(irq_in & mask_d);
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
      assign out_d[i] = pten_d[i] & irq_in[i];
    end else begin : g_idle
      assign out_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= out_d;
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int PT_LO     = 21,
  parameter int PT_HI     = 30,
  parameter int CASC      = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 psel,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [NUM_LINES-1:0] pwdata,
  output logic [NUM_LINES-1:0] prdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int PT_W = PT_HI - PT_LO + 1;
  localparam logic [NUM_LINES-1:0] PT_MASK = {{(NUM_LINES-PT_W){1'b0}}, {PT_W{1'b1}}} << PT_LO;

  logic [NUM_LINES-1:0] level_q, mask_q, pten_q, mask_d, pten_d;

  sic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PT_MASK(PT_MASK)) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in), .sel(psel), .wr(pwrite),
    .addr(paddr), .wdata(pwdata), .rdata(prdata),
    .level_q(level_q), .mask_q(mask_q), .pten_q(pten_q),
    .mask_d(mask_d), .pten_d(pten_d)
  );

  sic_route #(.NUM_LINES(NUM_LINES), .PT_LO(PT_LO), .PT_HI(PT_HI), .CASC(CASC),
              .PT_MASK(PT_MASK)) u_route (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_d(mask_d), .pten_d(pten_d),
    .irq_out(irq_out)
  );

  // R8
  cascade_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out[CASC] == |(level_q & mask_q));

  for (genvar i = PT_LO; i <= PT_HI; i++) begin : g_pt_chk
    // R7
    pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
      pten_q[i] |-> irq_out[i] == level_q[i]);
    // R7
    pass_off_chk: assert property (@(posedge clk) disable iff (rst)
      !pten_q[i] |-> !irq_out[i]);
  end
endmodule

// File: tb/sec_irq_ctrl_tb.sv
module sec_irq_ctrl_tb;
  localparam int N = 32;
  localparam logic [31:0] PTM = 32'h7FE0_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic psel = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [N-1:0] pwdata = '0;
  logic [N-1:0] prdata, irq_out;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sec_irq_ctrl u_dut (.clk(clk), .rst(rst), .irq_in(irq_in), .psel(psel),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_out(irq_out));

  // rows: {irq_in, mask, pass-through write value}
  localparam logic [95:0] VEC [6] = '{
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    {32'h4020_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
    {32'h1234_5678, 32'hF0F0_F0F0, 32'h2AA0_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h7FE0_0000},
    {32'h001F_FFFF, 32'h0010_0000, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] val);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(idx * 4); pwdata = val;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] val);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'(idx * 4);
    #1 val = prdata;
    psel = 1'b0;
  endtask

  function automatic logic [31:0] model_out(input logic [31:0] lv, input logic [31:0] m,
                                            input logic [31:0] pt);
    return (lv & pt & PTM) | {|(lv & m), 31'b0};
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    irq_in = '1;
    repeat (3) @(negedge clk);
    // R11 reset holds outputs and state low under active inputs
    check("R11 out in reset", irq_out, 32'h0);
    rd_reg(1, r); check("R11 raw in reset", r, 32'h0);
    irq_in = '0;
    rst = 1'b0;
    @(negedge clk);
    rd_reg(2, r); check("R11 mask after reset", r, 32'h0);
    rd_reg(8, r); check("R11 pt after reset", r, 32'h0);

    foreach (VEC[k]) begin
      logic [31:0] vin, vm, vp;
      {vin, vm, vp} = VEC[k];
      wr_reg(3, 32'hFFFF_FFFF);
      wr_reg(2, vm);
      wr_reg(9, 32'hFFFF_FFFF);
      wr_reg(8, vp);
      irq_in = vin;
      @(negedge clk);
      check($sformatf("R7/R8/R9 row %0d out", k), irq_out, model_out(vin, vm, vp));
      check($sformatf("R9 row %0d low lines", k), irq_out & 32'h001F_FFFF, 32'h0);
      rd_reg(0, r); check($sformatf("R2 row %0d status", k), r, vin & vm);
      rd_reg(1, r); check($sformatf("R1 row %0d raw", k), r, vin);
      rd_reg(2, r); check($sformatf("R3 row %0d enable", k), r, vm);
      rd_reg(8, r); check($sformatf("R5 row %0d pt", k), r, vp & PTM);
    end

    // R3 set/clear are cumulative
    wr_reg(3, 32'hFFFF_FFFF);
    wr_reg(2, 32'h0000_00F0);
    wr_reg(2, 32'h0000_0F00);
    wr_reg(3, 32'h0000_0110);
    rd_reg(2, r); check("R3 or/clear", r, 32'h0000_0EE0);

    // R4 soft interrupt pair
    wr_reg(3, 32'hFFFF_FFFF);
    irq_in = 32'h0000_0003;
    wr_reg(4, 32'h0);
    rd_reg(2, r); check("R4 zero set no effect", r, 32'h0);
    check("R4 cascade stays low", irq_out, 32'h0);
    wr_reg(4, 32'h0000_0100);
    rd_reg(2, r); check("R4 nonzero set", r, 32'h1);
    // R12 cascade rises on the write edge
    check("R12 cascade on write edge", irq_out, 32'h8000_0000);
    rd_reg(4, r); check("R4 soft read", r, 32'h1);
    wr_reg(5, 32'h0);
    rd_reg(2, r); check("R4 zero clr no effect", r, 32'h1);
    wr_reg(5, 32'h8000_0000);
    rd_reg(2, r); check("R4 nonzero clr", r, 32'h0);
    check("R4 cascade drops", irq_out, 32'h0);

    // R6/R7 pass-through release and mask independence
    irq_in = 32'h0020_0000;
    wr_reg(8, 32'h0060_0000);
    check("R7 pass line high mask off", irq_out, 32'h0020_0000);
    wr_reg(9, 32'h0020_0000);
    check("R6 pass line released", irq_out, 32'h0);
    rd_reg(8, r); check("R6 pt after clear", r, 32'h0040_0000);
    // R12 input change seen one edge later
    irq_in = 32'h0040_0000;
    check("R12 before edge", irq_out, 32'h0);
    @(negedge clk);
    check("R12 after edge", irq_out, 32'h0040_0000);

    // R10 holes in the map
    wr_reg(9, 32'hFFFF_FFFF);
    wr_reg(6, 32'hFFFF_FFFF);
    wr_reg(7, 32'hFFFF_FFFF);
    wr_reg(10, 32'hFFFF_FFFF);
    wr_reg(1023, 32'hFFFF_FFFF);
    wr_reg(0, 32'hFFFF_FFFF);
    wr_reg(1, 32'hFFFF_FFFF);
    rd_reg(2, r); check("R10 mask untouched", r, 32'h0);
    rd_reg(8, r); check("R10 pt untouched", r, 32'h0);
    check("R10 outputs untouched", irq_out, 32'h0);
    rd_reg(3, r);  check("R10 read idx3", r, 32'h0);
    rd_reg(6, r);  check("R10 read idx6", r, 32'h0);
    rd_reg(9, r);  check("R10 read idx9", r, 32'h0);
    rd_reg(1023, r); check("R10 read top", r, 32'h0);

    // R11 reset clears programmed state
    wr_reg(2, 32'hFFFF_FFFF);
    wr_reg(8, 32'hFFFF_FFFF);
    irq_in = '1;
    rst = 1'b1;
    @(negedge clk);
    check("R11 out after reset", irq_out, 32'h0);
    rst = 1'b0;
    rd_reg(2, r); check("R11 mask cleared", r, 32'h0);
    rd_reg(8, r); check("R11 pt cleared", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule